// File: doc/BRIEF.md
# Flash Block Protection Controller

This controller holds the write-protection state of 32 flash blocks. Each block is in one of three conditions: unlocked, locked, or locked-down. Software issues single-cycle command strobes that carry a 2-bit operation and a 5-bit block index. An active-low hardware write-protect pin decides whether the locked-down condition can be undone by software. An active-low reset/power-down input returns every block to locked.

Each block has two register bits. One is a lock bit, which gates program and erase. The other is a sticky lock-down mark, which only reset can clear. While write-protect is high, a marked block acts like an ordinary locked block and software may unlock it. When write-protect is driven low again, every marked block is relocked and cannot be unlocked. A query port reports, without delay, whether program and erase are allowed on any block. The full lock and lock-down vectors are also brought out.

Top module: `flash_lock_ctrl`

## Requirements
- R1: While `rst_n` is low, all 32 lock bits read 1, all lock-down marks read 0, `cmd_err` is 0, and commands are ignored. On release, every block is therefore locked.
- R2: A strobe with `cmd_op` = 2'b01 (lock) sets the lock bit of block `cmd_blk` at the next clock edge. Other blocks do not change.
- R3: A strobe with `cmd_op` = 2'b10 (unlock) clears the lock bit of block `cmd_blk` at the next edge when that block has no lock-down mark, or when `wp_n` is high. The lock-down mark itself is kept.
- R4: A strobe with `cmd_op` = 2'b11 (lock-down) sets both the lock bit and the lock-down mark of block `cmd_blk` at the next edge.
- R5: An unlock aimed at a marked block while `wp_n` is low leaves the lock bit set. `cmd_err` is then high for exactly the one cycle after that edge.
- R6: A lock-down mark stays set until reset. No command and no level of `wp_n` clears it.
- R7: At every clock edge where `wp_n` is sampled low, the lock bit of every marked block is set.
- R8: `qry_wr_ok` is 1 exactly when the lock bit of block `qry_blk` is 0. It follows `qry_blk` combinationally.
- R9: A cycle with `cmd_valid` low, or with `cmd_op` = 2'b00 (no-op), changes neither vector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset / power-down, asynchronous |
| wp_n | input | 1 | Active-low hardware write-protect, synchronous |
| cmd_valid | input | 1 | Single-cycle command strobe |
| cmd_op | input | 2 | 00 no-op, 01 lock, 10 unlock, 11 lock-down |
| cmd_blk | input | 5 | Block addressed by the command |
| qry_blk | input | 5 | Block whose program/erase permission is reported |
| qry_wr_ok | output | 1 | 1 when program and erase are allowed on `qry_blk` |
| cmd_err | output | 1 | One-cycle pulse after a rejected unlock |
| lock_vec | output | 32 | Lock bit of every block |
| ldn_vec | output | 32 | Lock-down mark of every block |

## Verification
Commands, and a low `wp_n`, take effect at the first rising edge after they are driven. The bench drives each one on a falling edge and compares both vectors against its model on the next falling edge. `cmd_err` is checked high at that same falling edge and low one falling edge later, which confirms it lasts one cycle. `qry_wr_ok` has no register in its path, so the bench steps `qry_blk` through all 32 blocks in sub-nanosecond steps inside one low clock phase and compares each result at once.

// File: rtl/flash_lock_ctrl.sv
module flash_lock_ctrl #(
  parameter int NBLK = 32,
  localparam int IDXW = $clog2(NBLK)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wp_n,
  input  logic            cmd_valid,
  input  logic [1:0]      cmd_op,
  input  logic [IDXW-1:0] cmd_blk,
  input  logic [IDXW-1:0] qry_blk,
  output logic            qry_wr_ok,
  output logic            cmd_err,
  output logic [NBLK-1:0] lock_vec,
  output logic [NBLK-1:0] ldn_vec
);
  localparam logic [1:0] OP_LOCK = 2'b01;
  localparam logic [1:0] OP_UNLK = 2'b10;
  localparam logic [1:0] OP_LDN  = 2'b11;

  logic [NBLK-1:0] lock_q, ldn_q, lock_d, ldn_d, sel;
  logic            err_d;

  assign sel = NBLK'(1) << cmd_blk;

  always_comb begin
    lock_d = lock_q;
    ldn_d  = ldn_q;
    err_d  = 1'b0;
    if (cmd_valid) begin
      case (cmd_op)
        OP_LOCK: lock_d = lock_q | sel;
        OP_UNLK: begin
          if (ldn_q[cmd_blk] && !wp_n) err_d = 1'b1;
          else                         lock_d = lock_q & ~sel;
        end
        OP_LDN: begin
          lock_d = lock_q | sel;
          ldn_d  = ldn_q | sel;
        end
        default: ;
      endcase
    end
    if (!wp_n) lock_d = lock_d | ldn_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lock_q  <= '1;
      ldn_q   <= '0;
      cmd_err <= 1'b0;
    end else begin
      lock_q  <= lock_d;
      ldn_q   <= ldn_d;
      cmd_err <= err_d;
    end
  end

  assign qry_wr_ok = ~lock_q[qry_blk];
  assign lock_vec  = lock_q;
  assign ldn_vec   = ldn_q;

  // R5: an error pulse follows only a rejected unlock
  assert_err_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_err |-> $past(cmd_valid && cmd_op == OP_UNLK && !wp_n && ldn_q[cmd_blk]));

  // R5: a rejected unlock leaves the block locked
  assert_reject_keeps_lock_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cmd_valid && cmd_op == OP_UNLK && !wp_n && ldn_q[cmd_blk])
      |-> lock_q[$past(cmd_blk)]);

  // R6: lock-down marks never clear outside reset
  assert_ldn_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ldn_q & $past(ldn_q)) == $past(ldn_q));

  // R9: marks only change after a lock-down command
  assert_ldn_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!(cmd_valid && cmd_op == OP_LDN)) |-> $stable(ldn_q));

  // R7: with write-protect low, every marked block is locked
  assert_wp_relock_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(wp_n) |-> ((ldn_q & ~lock_q) == '0));
endmodule

// File: tb/sim_flash_lock_ctrl.sv
`timescale 1ns/100ps
module sim_flash_lock_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wp_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic [1:0]  cmd_op = 2'b00;
  logic [4:0]  cmd_blk = '0;
  logic [4:0]  qry_blk = '0;
  logic        qry_wr_ok, cmd_err;
  logic [31:0] lock_vec, ldn_vec;
  logic [31:0] m_lock, m_ldn;
  int          n_run = 0, n_fail = 0;
  bit          done = 0;

  always #10 clk = ~clk;

  flash_lock_ctrl u0 (.clk, .rst_n, .wp_n, .cmd_valid, .cmd_op, .cmd_blk,
                      .qry_blk, .qry_wr_ok, .cmd_err, .lock_vec, .ldn_vec);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic chk_state(input string req);
    chk({req, " lock"}, lock_vec, m_lock);
    chk({req, " ldn"}, ldn_vec, m_ldn);
  endtask

  task automatic sweep_qry();
    for (int b = 0; b < 32; b++) begin
      qry_blk = 5'(b);
      #0.2;
      chk("R8 qry_wr_ok", {31'd0, qry_wr_ok}, {31'd0, ~m_lock[b]});
    end
  endtask

  task automatic cmd(input logic [1:0] op, input int b, input logic exp_err);
    cmd_valid = 1'b1; cmd_op = op; cmd_blk = 5'(b);
    @(negedge clk);
    cmd_valid = 1'b0; cmd_op = 2'b00;
    case (op)
      2'b01: m_lock[b] = 1'b1;
      2'b10: if (!(m_ldn[b] && !wp_n)) m_lock[b] = 1'b0;
      2'b11: begin m_lock[b] = 1'b1; m_ldn[b] = 1'b1; end
      default: ;
    endcase
    if (!wp_n) m_lock = m_lock | m_ldn;
    chk("R5 err pulse", {31'd0, cmd_err}, {31'd0, exp_err});
    if (exp_err) begin
      @(negedge clk);
      chk("R5 err one cycle", {31'd0, cmd_err}, 32'd0);
    end
  endtask

  task automatic set_wp(input logic v);
    wp_n = v;
    @(negedge clk);
    if (!v) m_lock = m_lock | m_ldn;
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    m_lock = '1; m_ldn = '0;
    @(negedge clk);
    // R1: commands during reset are ignored
    cmd_valid = 1'b1; cmd_op = 2'b10; cmd_blk = 5'd4;
    @(negedge clk); @(negedge clk);
    cmd_valid = 1'b0;
    chk_state("R1 in reset");
    chk("R1 err", {31'd0, cmd_err}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk_state("R1 after release");
    sweep_qry();

    // R3: unlock every block with write-protect low
    for (int b = 0; b < 32; b++) cmd(2'b10, b, 1'b0);
    chk_state("R3 unlock all wp low");
    sweep_qry();

    // R2: lock even blocks
    for (int b = 0; b < 32; b += 2) cmd(2'b01, b, 1'b0);
    chk_state("R2 lock evens");
    sweep_qry();

    // R9: no-op strobe and idle unlock pattern
    cmd(2'b00, 5, 1'b0);
    chk_state("R9 no-op");
    cmd_op = 2'b10; cmd_blk = 5'd4;
    @(negedge clk); @(negedge clk);
    cmd_op = 2'b00;
    chk_state("R9 valid low");

    // R4: lock-down three blocks
    cmd(2'b11, 3, 1'b0);
    cmd(2'b11, 7, 1'b0);
    cmd(2'b11, 31, 1'b0);
    chk_state("R4 lock-down");

    // R5: unlock a marked block with write-protect low
    cmd(2'b10, 7, 1'b1);
    chk_state("R5 rejected unlock");

    // R3/R6: write-protect high, marked blocks unlock and relock
    set_wp(1'b1);
    cmd(2'b10, 7, 1'b0);
    cmd(2'b10, 31, 1'b0);
    chk_state("R3 unlock marked wp high");
    chk("R6 marks kept", ldn_vec, 32'h8000_0088);
    cmd(2'b01, 31, 1'b0);
    cmd(2'b10, 31, 1'b0);
    chk_state("R3 relock unlock wp high");
    sweep_qry();

    // R7: write-protect low again restores lock-down
    set_wp(1'b0);
    chk_state("R7 relock on wp low");
    chk("R7 block 7 locked", {31'd0, lock_vec[7]}, 32'd1);
    cmd(2'b10, 31, 1'b1);
    cmd(2'b10, 1, 1'b0);
    chk_state("R7 after relock");
    sweep_qry();

    // R1/R6: reset clears marks and locks every block
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    m_lock = '1; m_ldn = '0;
    @(negedge clk);
    chk_state("R1 reset pulse");
    cmd(2'b10, 7, 1'b0);
    chk_state("R6 mark cleared by reset");

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule